// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is one counter channel of a programmable interval timer, reduced to its square-wave divider function. Software first writes a control byte to select the channel and its load order. It then writes a 16-bit divisor through an 8-bit data port as two bytes, least significant first. Once the second byte arrives, the channel divides an incoming count tick by that divisor. The result is a periodic square wave, intended as the system tick request line feeding interrupt input 0 of an interrupt controller.

The count tick is a synchronous enable (`tick_i`) sampled on the system clock, so the counting rate is set by whoever drives it. A typical setup uses a tick near 1.193 MHz with a divisor of 1193 (bytes A9h then 04h), which gives a wave period of about 1 ms. A new control byte stops the wave and parks it high. A fresh divisor can be loaded while the channel runs, and it takes effect as soon as its second byte lands.

Top module: `pit_timer_channel`

## Requirements
- R1: While reset is held and after it is released, `wave_o` is 1, the channel is idle, and the next data byte is treated as the low byte.
- R2: A write happens on a rising clock edge where both `cs_i` and `wr_i` are 1. Offset 3 is the control register and offset 0 is the divisor data register. A write with `cs_i` at 0, or to offset 1 or 2, changes nothing.
- R3: A control byte is accepted only when bits 7:6 = 00 (channel 0), bits 5:4 = 11 (low byte then high byte), bits 2:1 = 11 (square wave, so bits 3:1 of 011 or 111 both qualify) and bit 0 = 0 (binary), for example 36h or 3Eh. Any other control byte leaves the output and the byte order untouched.
- R4: Data writes made before any control byte has been accepted are ignored.
- R5: An accepted control byte drives `wave_o` to 1 from the clock edge that writes it. It stops counting and makes the next data byte the low byte. The output stays high until both bytes of a new divisor are written.
- R6: A low byte on its own does not start the channel. The high-byte write arms it: `wave_o` is 1 at that edge, and counting starts with the next tick.
- R7: For a divisor N of 2 or more, the high phase lasts ceil(N/2) ticks and the low phase floor(N/2) ticks. For N = 1193 that gives 597 ticks high and 596 ticks low.
- R8: After each full period the channel reloads the stored divisor by itself, so the period repeats without further writes.
- R9: A divisor of 0 stands for 65536, giving 32768 ticks high.
- R10: A divisor of 1 keeps `wave_o` at 1.
- R11: Only clock edges with `tick_i` at 1 advance the count. With no tick and no write, `wave_o` holds its value.
- R12: Writing a new divisor (both bytes) while the channel runs restarts it at once with a high phase of the new length, whatever phase it was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one tick per clock where high |
| cs_i | input | 1 | Chip select for bus writes |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (2) | Register offset |
| wdata_i | input | BUS_W (8) | Write data |
| wave_o | output | 1 | Square-wave output, tick request line |

## Verification
Writes take effect on the rising edge that samples `cs_i` and `wr_i`, and `wave_o` is registered on that same edge. A forced-high or re-armed output is therefore due at the falling edge right after the write, and the bench samples it there. Phase lengths are due in ticks rather than cycles. The bench keeps a running count of ticks applied at rising edges and reads it at the falling edges where the output level changes, so a random tick pattern still yields exact ceil and floor phase lengths. Divisor changes are measured either from the arming edge or after syncing to a rising transition, which keeps each measurement free of leftover phase from earlier stimulus.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Field codes of the control byte
   localparam logic [1:0] SEL_CH0   = 2'b00;
   localparam logic [1:0] ACC_LOHI  = 2'b11;
   localparam logic [2:0] MODE_SQW  = 3'b011;
   localparam logic       CNT_BIN   = 1'b0;
   localparam int         CTRL_BITS = 8;

   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_word_t;

endpackage

// File: rtl/pit_bus_if.sv
module pit_bus_if
   import pit_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int BUS_W      = 8,
   parameter int CTRL_OFS   = 3,
   parameter int DATA_OFS   = 0,
   parameter bit MODE_ALIAS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [BUS_W-1:0]   wdata_i,
   output logic               stop_o,
   output logic               load_o,
   output logic [2*BUS_W-1:0] load_val_o
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic             wr_stb;
   ctrl_word_t       cw;
   logic             mode_ok;
   logic             ctrl_hit;
   logic             data_hit;
   logic             cfg_q;
   logic             hi_next_q;
   logic [BUS_W-1:0] lo_q;

   assign wr_stb = cs_i && wr_i;
   assign cw     = ctrl_word_t'(wdata_i[CTRL_BITS-1:0]);

   generate
      if (MODE_ALIAS) begin : g_mode_alias
         assign mode_ok = (cw.mode[1:0] == MODE_SQW[1:0]);
      end else begin : g_mode_exact
         assign mode_ok = (cw.mode == MODE_SQW);
      end
   endgenerate

   assign ctrl_hit = wr_stb && (addr_i == CTRL_A) && (cw.sel == SEL_CH0)
                     && (cw.acc == ACC_LOHI) && mode_ok && (cw.bcd == CNT_BIN);
   assign data_hit = wr_stb && (addr_i == DATA_A) && cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q     <= 1'b0;
         hi_next_q <= 1'b0;
         lo_q      <= '0;
      end else if (ctrl_hit) begin
         cfg_q     <= 1'b1;
         hi_next_q <= 1'b0;
      end else if (data_hit) begin
         if (!hi_next_q) begin
            lo_q      <= wdata_i;
            hi_next_q <= 1'b1;
         end else begin
            hi_next_q <= 1'b0;
         end
      end
   end

   assign stop_o     = ctrl_hit;
   assign load_o     = data_hit && hi_next_q;
   assign load_val_o = {wdata_i, lo_q};

endmodule

// File: rtl/pit_phase_gen.sv
module pit_phase_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             wave_o
);

   localparam int PW = CNT_W + 1;

   logic          armed_q;
   logic          wave_q;
   logic [PW-1:0] period_q;
   logic [PW-1:0] remain_q;
   logic [PW-1:0] ld_len;
   logic [PW-1:0] ld_hi;
   logic [PW-1:0] hi_len;
   logic [PW-1:0] lo_len;

   always_comb begin
      ld_len = (load_val_i == '0) ? (PW'(1) << CNT_W) : {1'b0, load_val_i};
      ld_hi  = (ld_len + PW'(1)) >> 1;
      hi_len = (period_q + PW'(1)) >> 1;
      lo_len = period_q >> 1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         wave_q   <= 1'b1;
         period_q <= '0;
         remain_q <= '0;
      end else if (stop_i) begin
         armed_q <= 1'b0;
         wave_q  <= 1'b1;
      end else if (load_i) begin
         armed_q  <= 1'b1;
         wave_q   <= 1'b1;
         period_q <= ld_len;
         remain_q <= ld_hi;
      end else if (armed_q && tick_i) begin
         if (remain_q == PW'(1)) begin
            if (wave_q && (lo_len == '0)) begin
               remain_q <= hi_len;
            end else begin
               wave_q   <= ~wave_q;
               remain_q <= wave_q ? lo_len : hi_len;
            end
         end else begin
            remain_q <= remain_q - PW'(1);
         end
      end
   end

   assign wave_o = wave_q;

endmodule

// File: rtl/pit_timer_channel.sv
module pit_timer_channel #(
   parameter int ADDR_W     = 2,
   parameter int BUS_W      = 8,
   parameter int CTRL_OFS   = 3,
   parameter int DATA_OFS   = 0,
   parameter bit MODE_ALIAS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              cs_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic              wave_o
);

   localparam int CNT_W = 2 * BUS_W;

   generate
      if (BUS_W < pit_pkg::CTRL_BITS) begin : g_bad_bus
         $error("BUS_W must hold a full control byte");
      end
      if (CTRL_OFS == DATA_OFS) begin : g_bad_ofs
         $error("control and data offsets must differ");
      end
      if ((CTRL_OFS >= (1 << ADDR_W)) || (DATA_OFS >= (1 << ADDR_W))) begin : g_bad_addr
         $error("register offset outside the address range");
      end
   endgenerate

   logic             stop;
   logic             load;
   logic [CNT_W-1:0] load_val;

   pit_bus_if #(
      .ADDR_W     (ADDR_W),
      .BUS_W      (BUS_W),
      .CTRL_OFS   (CTRL_OFS),
      .DATA_OFS   (DATA_OFS),
      .MODE_ALIAS (MODE_ALIAS)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_i       (cs_i),
      .wr_i       (wr_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .stop_o     (stop),
      .load_o     (load),
      .load_val_o (load_val)
   );

   pit_phase_gen #(
      .CNT_W (CNT_W)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .stop_i     (stop),
      .load_i     (load),
      .load_val_i (load_val),
      .wave_o     (wave_o)
   );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
   parameter int ADDR_W   = 2,
   parameter int BUS_W    = 8,
   parameter int CTRL_OFS = 3,
   parameter int DATA_OFS = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              cs_i,
   input logic              wr_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [BUS_W-1:0]  wdata_i,
   input logic              wave_o
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   // R5: an accepted control byte parks the output high
   a_r5_ctrl_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && addr_i == CTRL_A && wdata_i[7:0] == 8'h36) |=> wave_o);

   // R11: no tick and no write means no change
   a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !(cs_i && wr_i)) |=> $stable(wave_o));

   // R2: unused offsets have no effect
   a_r2_unused_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && addr_i != CTRL_A && addr_i != DATA_A && !tick_i)
      |=> $stable(wave_o));

   // R2: strobe without select has no effect
   a_r2_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !cs_i && !tick_i) |=> $stable(wave_o));

   // R3: control bytes for other channels are ignored
   a_r3_other_channel: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && wr_i && addr_i == CTRL_A && wdata_i[7:6] != 2'b00 && !tick_i)
      |=> $stable(wave_o));

endmodule

bind pit_timer_channel pit_timer_chk #(
   .ADDR_W   (ADDR_W),
   .BUS_W    (BUS_W),
   .CTRL_OFS (CTRL_OFS),
   .DATA_OFS (DATA_OFS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_i  (tick_i),
   .cs_i    (cs_i),
   .wr_i    (wr_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .wave_o  (wave_o)
);

// File: tb/sim_pit_timer_channel.sv
module sim_pit_timer_channel;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b1;
   logic       cs_i = 1'b0;
   logic       wr_i = 1'b0;
   logic [1:0] addr_i = 2'd0;
   logic [7:0] wdata_i = 8'd0;
   logic       wave_o;

   int total = 0;
   int bad = 0;
   int tick_cnt = 0;
   int tick_mode = 0;   // 0 always, 1 random, 2 off

   pit_timer_channel u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .cs_i    (cs_i),
      .wr_i    (wr_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .wave_o  (wave_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) if (tick_i) tick_cnt <= tick_cnt + 1;

   always @(negedge clk) begin
      if (tick_mode == 1)      tick_i <= 1'($urandom % 2);
      else if (tick_mode == 2) tick_i <= 1'b0;
      else                     tick_i <= 1'b1;
   end

   function automatic int hi_of(int n);
      int e = (n == 0) ? 65536 : n;
      return (e + 1) / 2;
   endfunction

   function automatic int lo_of(int n);
      int e = (n == 0) ? 65536 : n;
      return e / 2;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [1:0] a, logic [7:0] d, bit sel = 1'b1);
      @(negedge clk);
      cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      cs_i = 1'b0; wr_i = 1'b0;
   endtask

   task automatic load(int n);
      wr_reg(2'd0, 8'(n & 255));
      wr_reg(2'd0, 8'((n >> 8) & 255));
   endtask

   task automatic hold_high(int n, string req);
      int lows = 0;
      for (int i = 0; i < n; i++) begin
         if (wave_o !== 1'b1) lows++;
         @(negedge clk);
      end
      check(lows == 0, req, lows, 0);
   endtask

   // call right after the high-byte write returns
   task automatic first_high(int exp_h, string req);
      int t0 = tick_cnt;
      int g = 0;
      check(wave_o === 1'b1, req, int'(wave_o), 1);
      while (wave_o === 1'b1 && g < 140000) begin @(negedge clk); g++; end
      check(tick_cnt - t0 == exp_h, req, tick_cnt - t0, exp_h);
   endtask

   task automatic measure(int exp_h, int exp_l, string req);
      int g = 0;
      int t0, t1;
      while (wave_o !== 1'b0 && g < 140000) begin @(negedge clk); g++; end
      while (wave_o !== 1'b1 && g < 140000) begin @(negedge clk); g++; end
      t0 = tick_cnt;
      while (wave_o === 1'b1 && g < 140000) begin @(negedge clk); g++; end
      t1 = tick_cnt;
      while (wave_o === 1'b0 && g < 140000) begin @(negedge clk); g++; end
      check(t1 - t0 == exp_h, req, t1 - t0, exp_h);
      check(tick_cnt - t1 == exp_l, req, tick_cnt - t1, exp_l);
   endtask

   task automatic wait_low();
      int g = 0;
      while (wave_o !== 1'b0 && g < 1000) begin @(negedge clk); g++; end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [7:0] bad_cw [5];
      logic       v;
      int         changes;
      void'($urandom(32'd2024));
      bad_cw = '{8'h34, 8'h37, 8'h76, 8'h06, 8'h26};

      repeat (3) @(negedge clk);
      check(wave_o === 1'b1, "R1 reset level", int'(wave_o), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(wave_o === 1'b1, "R1 after reset", int'(wave_o), 1);

      // R4: data before any accepted control byte
      load(1193);
      hold_high(30, "R4 unconfigured data");

      // R3: rejected control bytes leave the channel unconfigured
      foreach (bad_cw[i]) begin
         wr_reg(2'd3, bad_cw[i]);
         load(10);
         hold_high(20, "R3 rejected control byte");
      end

      // R6, R7, R8: standard 1 ms setup
      wr_reg(2'd3, 8'h36);
      wr_reg(2'd0, 8'hA9);
      hold_high(40, "R6 low byte alone");
      wr_reg(2'd0, 8'h04);
      first_high(597, "R6 arm on high byte");
      measure(597, 596, "R7 divisor 1193");
      measure(597, 596, "R8 reload");

      // R12: new divisor during low phase
      wait_low();
      load(10);
      first_high(5, "R12 restart");
      measure(5, 5, "R7 even divisor");
      measure(5, 5, "R8 reload even");

      load(3);  first_high(2, "R7 divisor 3"); measure(2, 1, "R7 divisor 3");
      load(2);  measure(1, 1, "R7 divisor 2");
      load(7);  measure(4, 3, "R7 divisor 7");

      // R10
      load(1);
      hold_high(50, "R10 divisor 1");

      // R5: control byte mid-run
      load(8);
      wait_low();
      wr_reg(2'd3, 8'h36);
      check(wave_o === 1'b1, "R5 forced high", int'(wave_o), 1);
      hold_high(30, "R5 stopped");
      wr_reg(2'd0, 8'h08);
      hold_high(20, "R5 low byte only");
      wr_reg(2'd0, 8'h00);
      first_high(4, "R5 reload after stop");
      measure(4, 4, "R5 divisor 8");

      // R5: control byte resets the byte order
      wr_reg(2'd3, 8'h36);
      wr_reg(2'd0, 8'h55);
      wr_reg(2'd3, 8'h36);
      load(6);
      first_high(3, "R5 byte order reset");
      measure(3, 3, "R5 byte order reset");

      // R3: mode alias 3Eh accepted
      wr_reg(2'd3, 8'h3E);
      load(9);
      first_high(5, "R3 alias control byte");
      measure(5, 4, "R3 alias control byte");

      // R2, R3: ignored writes while running
      load(10);
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd0, 8'h00, 1'b0);
      wr_reg(2'd3, 8'h76);
      wr_reg(2'd3, 8'h34);
      measure(5, 5, "R2 R3 ignored writes");
      load(4);
      first_high(2, "R3 byte order untouched");

      // R11: ticks off
      tick_mode = 2;
      repeat (2) @(negedge clk);
      v = wave_o;
      changes = 0;
      for (int i = 0; i < 40; i++) begin
         if (wave_o !== v) changes++;
         @(negedge clk);
      end
      check(changes == 0, "R11 no tick", changes, 0);

      // R11, R7: random ticks, random divisors
      tick_mode = 1;
      for (int i = 0; i < 8; i++) begin
         int n = 2 + int'($urandom % 30);
         load(n);
         measure(hi_of(n), lo_of(n), "R11 random ticks");
      end
      tick_mode = 0;
      repeat (2) @(negedge clk);

      // R9
      load(0);
      first_high(hi_of(0), "R9 divisor zero");

      finish_run();
   end

endmodule